// File: doc/BRIEF.md
# Latency-Insensitive Core Wrapper with Bypassable Input Slots

This block sits around a synchronous compute core in a latency-insensitive fabric. Several input lanes bring data tokens, each marked by a valid flag. The wrapper lets the core advance by one step only when every lane has a token to offer and the consumer is not stalling. The wrapper then returns a stop signal to each lane. A stop tells that producer to hold back its next token.

Each lane has a one-entry side slot. A token that arrives while the wrapper must wait is parked in that slot. The lane then raises stop until the token has been used. A token that arrives in the same cycle as all the others goes straight from the wire into the core, so no cycle is added when traffic is balanced. The core here is a registered sum of one token from each lane. The result comes out one cycle after the wrapper fires.

Upstream contract: a producer that sees stop high in a cycle keeps valid low in the following cycle. Downstream contract: the consumer accepts every cycle in which the output valid is high.

Top module: `li_shell_wrap`

## Requirements
- R1: A synchronous active-high reset empties every slot, drives `out_valid` low, clears `out_data` to zero and holds every `in_stop` low during reset.
- R2: The core fires in a cycle only if every lane has a token (parked or on its wire) and `out_stop` is low. `out_valid` in the next cycle equals that fire decision, and nothing fires while `out_stop` is high.
- R3: On a fire, `out_data` in the next cycle is the unsigned sum of one token per lane. Lane i occupies bits [i*DW +: DW] of `in_data`. A lane with a parked token contributes the parked token instead of its wire.
- R4: A lane whose wire carries a valid token in a cycle where the core does not fire parks that token and raises its `in_stop` in that same cycle.
- R5: `in_stop[i]` is high exactly when lane i still holds a parked token at the end of the cycle. A producer must keep valid low in the cycle after its stop.
- R6: A fire consumes every parked token, and every `in_stop` is low in the firing cycle.
- R7: `out_data` does not change while `out_valid` is low.
- R8: Every token delivered on every lane appears in exactly one output sum, in arrival order, with no loss and no duplication.
- R9: When all lanes present tokens in the same cycle with `out_stop` low, the result is valid in the very next cycle and no stop is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | LANES*DW | Lane tokens, lane i at bits [i*DW +: DW] |
| in_valid | input | LANES | Token present on each lane wire |
| in_stop | output | LANES | Stop returned to each lane producer |
| out_valid | output | 1 | Result valid, one cycle after a fire |
| out_data | output | DW+$clog2(LANES) | Registered sum of the consumed tokens |
| out_stop | input | 1 | Consumer stall; blocks firing |

## Verification
The interesting collision is a fire in which some lanes release parked tokens while others bypass fresh tokens straight off their wires. In that same cycle a lane may also try to park while the consumer stalls. The bench forces this by parking lane 0 alone and later delivering the remaining lanes together. It also asserts `out_stop` over a fully present set, and then runs long random traffic with random stalls. A behavioural per-lane token model predicts the stop vector, the fire decision and the exact sum every cycle. Mixing buffered and wire operands therefore shows up as a wrong sum, a lost or duplicated token, or a stop left high after a fire.

// File: rtl/li_shell_pkg.sv
package li_shell_pkg;
    localparam int unsigned DEF_LANES = 3;
    localparam int unsigned DEF_DW    = 8;

    typedef enum logic {
        SLOT_EMPTY  = 1'b0,
        SLOT_PARKED = 1'b1
    } slot_state_e;
endpackage

// File: rtl/li_in_slot.sv
module li_in_slot
    import li_shell_pkg::*;
#(
    parameter int unsigned DW = DEF_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wire_valid,
    input  logic [DW-1:0] wire_data,
    input  logic          fire,
    output logic          present,
    output logic [DW-1:0] opnd,
    output logic          stop_up
);
    typedef struct packed {
        slot_state_e   st;
        logic [DW-1:0] data;
    } slot_t;

    slot_t slot_q, slot_d;
    logic  parked;

    assign parked = (slot_q.st == SLOT_PARKED);

    always_comb begin
        slot_d = slot_q;
        if (fire) begin
            // the parked token (if any) is consumed by this firing
            slot_d.st = SLOT_EMPTY;
        end else if (wire_valid) begin
            // token arrived but the core must wait: park it
            slot_d.st   = SLOT_PARKED;
            slot_d.data = wire_data;
        end
        present = parked || wire_valid;
        opnd    = parked ? slot_q.data : wire_data;
        stop_up = (slot_d.st == SLOT_PARKED);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '{st: SLOT_EMPTY, data: '0};
        end else begin
            slot_q <= slot_d;
        end
    end
endmodule

// File: rtl/li_fire_ctrl.sv
module li_fire_ctrl
    import li_shell_pkg::*;
#(
    parameter int unsigned LANES = DEF_LANES
) (
    input  logic [LANES-1:0] present,
    input  logic             out_stop,
    output logic             fire
);
    always_comb begin
        fire = (&present) && !out_stop;
    end
endmodule

// File: rtl/li_sum_core.sv
module li_sum_core
    import li_shell_pkg::*;
#(
    parameter int unsigned LANES = DEF_LANES,
    parameter int unsigned DW    = DEF_DW,
    parameter int unsigned SUM_W = DW + $clog2(LANES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fire,
    input  logic [LANES*DW-1:0] opnds,
    output logic                res_valid,
    output logic [SUM_W-1:0]    res_data
);
    typedef struct packed {
        logic             valid;
        logic [SUM_W-1:0] data;
    } res_t;

    res_t res_q, res_d;

    always_comb begin
        logic [SUM_W-1:0] acc;
        acc = '0;
        for (int k = 0; k < int'(LANES); k++) begin
            acc = acc + SUM_W'(opnds[k*DW +: DW]);
        end
        res_d       = res_q;
        res_d.valid = fire;
        if (fire) begin
            res_d.data = acc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '{valid: 1'b0, data: '0};
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid = res_q.valid;
    assign res_data  = res_q.data;
endmodule

// File: rtl/li_shell_wrap.sv
module li_shell_wrap
    import li_shell_pkg::*;
#(
    parameter int unsigned LANES = DEF_LANES,
    parameter int unsigned DW    = DEF_DW,
    localparam int unsigned SUM_W = DW + $clog2(LANES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [LANES*DW-1:0] in_data,
    input  logic [LANES-1:0]    in_valid,
    output logic [LANES-1:0]    in_stop,
    output logic                out_valid,
    output logic [SUM_W-1:0]    out_data,
    input  logic                out_stop
);
    logic [LANES-1:0]    present_w;
    logic [LANES*DW-1:0] opnd_w;
    logic                fire_w;

    for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
        li_in_slot #(.DW(DW)) slot_i (
            .clk        (clk),
            .rst        (rst),
            .wire_valid (in_valid[g]),
            .wire_data  (in_data[g*DW +: DW]),
            .fire       (fire_w),
            .present    (present_w[g]),
            .opnd       (opnd_w[g*DW +: DW]),
            .stop_up    (in_stop[g])
        );
    end

    li_fire_ctrl #(.LANES(LANES)) ctrl_i (
        .present  (present_w),
        .out_stop (out_stop),
        .fire     (fire_w)
    );

    li_sum_core #(.LANES(LANES), .DW(DW), .SUM_W(SUM_W)) core_i (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire_w),
        .opnds     (opnd_w),
        .res_valid (out_valid),
        .res_data  (out_data)
    );
endmodule

// File: rtl/li_shell_wrap_chk.sv
module li_shell_wrap_chk #(
    parameter int unsigned LANES = 3,
    parameter int unsigned SUM_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic [LANES-1:0] in_valid,
    input logic [LANES-1:0] in_stop,
    input logic             out_valid,
    input logic [SUM_W-1:0] out_data,
    input logic             out_stop,
    input logic             fire_w
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> !out_valid);

    assert_fire_sets_valid_R2: assert property (@(posedge clk) disable iff (rst)
        fire_w |=> out_valid);

    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
        !fire_w |=> !out_valid);

    assert_stall_blocks_fire_R2: assert property (@(posedge clk) disable iff (rst)
        out_stop |-> !fire_w);

    assert_hold_data_R7: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

    for (genvar g = 0; g < int'(LANES); g++) begin : g_lane_chk
        assert_park_raises_stop_R4: assert property (@(posedge clk) disable iff (rst)
            (in_valid[g] && !fire_w) |-> in_stop[g]);

        assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
            in_stop[g] |=> !in_valid[g]);

        assert_fire_frees_slot_R6: assert property (@(posedge clk) disable iff (rst)
            fire_w |-> !in_stop[g]);
    end
endmodule

bind li_shell_wrap li_shell_wrap_chk #(.LANES(LANES), .SUM_W(SUM_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_stop   (in_stop),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_stop  (out_stop),
    .fire_w    (fire_w)
);

// File: tb/li_shell_wrap_tb_top.sv
`timescale 1ns/1ps
module li_shell_wrap_tb_top;
    localparam int LANES = 3;
    localparam int DW    = 8;
    localparam int SUM_W = DW + $clog2(LANES);

    logic                clk = 1'b0;
    logic                rst;
    logic [LANES*DW-1:0] in_data;
    logic [LANES-1:0]    in_valid;
    logic [LANES-1:0]    in_stop;
    logic                out_valid;
    logic [SUM_W-1:0]    out_data;
    logic                out_stop;

    always #4 clk = ~clk;

    li_shell_wrap #(.LANES(LANES), .DW(DW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_stop   (in_stop),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_stop  (out_stop)
    );

    int n_cmp = 0;
    int n_bad = 0;
    // behavioural token model: one pending token per lane at most
    bit [LANES-1:0] have;
    int             val [LANES];
    int             sent [LANES];
    bit             exp_v;
    int             exp_d;
    int             fires;
    int             outs_seen;
    logic [LANES-1:0] stop_seen;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_cycle();
        bit all_in;
        int s;
        for (int i = 0; i < LANES; i++) begin
            if (in_valid[i]) begin
                have[i] = 1'b1;
                val[i]  = int'(in_data[i*DW +: DW]);
                sent[i]++;
            end
        end
        check(out_valid == exp_v, "R2 out_valid follows fire", int'(out_valid), int'(exp_v));
        check(int'(out_data) == exp_d, exp_v ? "R3 output sum" : "R7 held data",
              int'(out_data), exp_d);
        if (out_valid) outs_seen++;
        all_in = &have;
        exp_v  = all_in && !out_stop;
        if (exp_v) begin
            s = 0;
            for (int i = 0; i < LANES; i++) s += val[i];
            exp_d = s;
            fires++;
            have = '0;
        end
        for (int i = 0; i < LANES; i++) begin
            check(in_stop[i] == have[i], "R5 stop reflects parked token",
                  int'(in_stop[i]), int'(have[i]));
        end
        stop_seen = in_stop;
    endtask

    task automatic step(input logic [LANES-1:0] v, input logic os);
        @(posedge clk);
        #1;
        in_valid = v & ~stop_seen;
        for (int i = 0; i < LANES; i++) in_data[i*DW +: DW] = DW'($urandom);
        out_stop = os;
        @(negedge clk);
        model_cycle();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        have = '0; exp_v = 1'b0; exp_d = 0; fires = 0; outs_seen = 0; stop_seen = '0;
        for (int i = 0; i < LANES; i++) begin val[i] = 0; sent[i] = 0; end
        rst = 1'b1; in_valid = '0; in_data = '0; out_stop = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 reset valid low", int'(out_valid), 0);
        check(in_stop == '0, "R1 reset stops low", int'(in_stop), 0);
        check(out_data == '0, "R1 reset data zero", int'(out_data), 0);
        rst = 1'b0;

        // R9: balanced arrival passes straight through
        step('1, 1'b0);
        check(in_stop == '0, "R9 no stop on balanced arrival", int'(in_stop), 0);
        step('0, 1'b0);
        check(out_valid == 1'b1, "R9 result next cycle", int'(out_valid), 1);

        // R4 / R6: lane 0 parks, others arrive later and mix with the slot
        step(3'b001, 1'b0);
        check(in_stop[0] == 1'b1, "R4 lone token parks", int'(in_stop[0]), 1);
        step(3'b000, 1'b0);
        check(in_stop[0] == 1'b1, "R5 parked stop held", int'(in_stop[0]), 1);
        step(3'b110, 1'b0);
        check(in_stop == '0, "R6 fire frees slot", int'(in_stop), 0);
        step(3'b000, 1'b0);
        check(out_valid == 1'b1, "R6 mixed fire produced result", int'(out_valid), 1);

        // R2: consumer stall parks a complete set
        step('1, 1'b1);
        check(in_stop == '1, "R2 stall parks all lanes", int'(in_stop), 7);
        step('0, 1'b0);
        check(out_valid == 1'b0, "R2 no result under stall", int'(out_valid), 0);
        check(in_stop == '0, "R6 parked set fires", int'(in_stop), 0);
        step('0, 1'b0);
        check(out_valid == 1'b1, "R2 result after stall", int'(out_valid), 1);

        // random traffic with random stalls
        for (int n = 0; n < 3000; n++) begin
            logic [LANES-1:0] v;
            for (int i = 0; i < LANES; i++) v[i] = ($urandom % 10) < 6;
            step(v, ($urandom % 4) == 0);
        end

        // drain: top up lanes that lack a token
        for (int n = 0; n < 20 && have != '0; n++) step(~have, 1'b0);
        step('0, 1'b0);
        step('0, 1'b0);
        check(have == '0, "R8 drained", int'(have), 0);
        check(outs_seen == fires, "R8 one output per fire", outs_seen, fires);
        for (int i = 0; i < LANES; i++) begin
            check(sent[i] == fires, "R8 every token consumed once", sent[i], fires);
        end
        finish_run();
    end
endmodule